// File: doc/BRIEF.md
# Crosspoint Routing Configuration Interface

This block holds the routing map of a 33-input, 17-output crosspoint switch and includes a behavioural model of the switch itself. Each output owns a 7-bit route word. The low six bits hold the binary index of the input to connect, and the top bit enables the output driver. A host writes route words one output at a time into a staging rank, using an address bus and a shared bidirectional data bus. A single global commit strobe then copies every staged word into the active rank in the same clock edge, so the whole switch changes configuration at once.

All strobes are active low and are sampled on the rising edge of a system clock. They act for as long as they are held. A chip select gates write, commit and readback. Readback drives the addressed output's active word onto the data bus. A separate active-low disable input clears the enable bit of every active word at once, regardless of chip select. It leaves the staging rank and the active select bits alone. Its release is synchronised to the clock.

Top module: `xbar_cfg_top`

## Requirements
- R1: With `cs_n` and `wr_n` low at a rising clock edge, the 7-bit word on `cfg_data` is stored in the staging entry of the output given by the binary address `cfg_addr` (bit 4 most significant). Other entries are unchanged.
- R2: With `cs_n` and `commit_n` low at a rising clock edge, all 17 staging entries are copied into the active rank in that edge, whatever the value of `cfg_addr`.
- R3: The switch routing and the readback value follow only the active rank. A write without a commit changes neither.
- R4: Route word encoding: bit 6 is the enable and bits 5..0 are the input index. When bit 6 is 1, `sw_out[k]` equals `sw_in[index]`. When bit 6 is 0, `sw_out[k]` is high impedance.
- R5: An enabled output whose index is 33 or higher drives 0.
- R6: While `cs_n` and `rd_n` are both low, `cfg_data` carries the active word of the addressed output. Otherwise the block does not drive `cfg_data`.
- R7: Writes to addresses 17 to 31 change no entry, and readback of those addresses returns 0.
- R8: While `cs_n` is high, write, commit and readback have no effect.
- R9: While `dis_n` is low, the enable bit of every active entry is 0, from the moment `dis_n` falls and regardless of `cs_n`. Active select bits and the staging rank keep their contents. A commit made after release restores the staged words.
- R10: When a write and a commit fall in the same clock edge, the commit copies the staging value held before that write. The newly written word reaches the active rank at the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes sampled on rising edge |
| dis_n | input | 1 | Asynchronous active-low global output disable |
| cs_n | input | 1 | Active-low chip select for the host interface |
| wr_n | input | 1 | Active-low staging write enable |
| commit_n | input | 1 | Active-low global commit of staging to active |
| rd_n | input | 1 | Active-low readback enable |
| cfg_addr | input | 5 | Output address, binary |
| cfg_data | inout | 7 | Route word in (write) or out (readback) |
| sw_in | input | 33 | Switch matrix inputs |
| sw_out | output | 17 | Switch matrix outputs, Z when disabled |

## Verification
The two functions that can share a cycle are a staging write and the global commit. Both strobes are held low for a single clock edge, with a new word addressed to an entry whose staged value is already known. The bench judges the case by readback: right after that edge the entry must show the earlier staged word. After one more plain commit it must show the new word. A second coincidence is the global disable falling while chip select is high. The bench checks that the outputs turn off before the next clock edge, and that the select bits remain readable.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int unsigned XB_N_IN   = 33;
  localparam int unsigned XB_N_OUT  = 17;
  localparam int unsigned XB_SEL_W  = 6;
  localparam int unsigned XB_ADDR_W = 5;
  localparam int unsigned XB_SYNC_STAGES = 2;
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xbar_stage_rank.sv
module xbar_stage_rank #(
  parameter int unsigned N_OUT  = 17,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_req,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [N_OUT*WORD_W-1:0] stage_o
);
  logic [N_OUT-1:0] row_wen;

  for (genvar i = 0; i < N_OUT; i++) begin : g_row
    logic [WORD_W-1:0] row_q;
    logic [WORD_W-1:0] row_d;

    assign row_wen[i] = wr_req && (waddr == ADDR_W'(i));

    always_comb begin
      row_d = row_q;
      if (row_wen[i]) row_d = wdata;
    end

    always_ff @(posedge clk) begin
      row_q <= row_d;
    end

    assign stage_o[i*WORD_W +: WORD_W] = row_q;

    AST_STAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && waddr == ADDR_W'(i)) |=> stage_o[i*WORD_W +: WORD_W] == $past(wdata)); // R1
  end

  AST_STAGE_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && waddr >= ADDR_W'(N_OUT)) |=> $stable(stage_o)); // R7
endmodule

// File: rtl/xbar_active_rank.sv
module xbar_active_rank #(
  parameter int unsigned N_OUT  = 17,
  parameter int unsigned WORD_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_req,
  input  logic [N_OUT*WORD_W-1:0] stage_i,
  output logic [N_OUT*WORD_W-1:0] act_o
);
  localparam int unsigned SEL_W = WORD_W - 1;

  logic [N_OUT-1:0] en_vec;

  for (genvar i = 0; i < N_OUT; i++) begin : g_row
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             en_q, en_d;

    always_comb begin
      sel_d = sel_q;
      en_d  = en_q;
      if (upd_req) begin
        sel_d = stage_i[i*WORD_W +: SEL_W];
        en_d  = stage_i[i*WORD_W + SEL_W];
      end
    end

    always_ff @(posedge clk) begin
      sel_q <= sel_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_d;
    end

    assign en_vec[i] = en_q;
    assign act_o[i*WORD_W +: WORD_W] = {en_q, sel_q};
  end

  AST_ACT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> act_o == $past(stage_i)); // R2
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_req |=> $stable(act_o)); // R3

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_EN_CLEAR: assert (en_vec == '0); // R9
    end
  end
endmodule

// File: rtl/xbar_readback.sv
module xbar_readback #(
  parameter int unsigned N_OUT  = 17,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned WORD_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       raddr,
  input  logic [N_OUT*WORD_W-1:0] act_i,
  output logic                    rb_oe,
  output logic [WORD_W-1:0]       rb_data
);
  always_comb begin
    rb_data = '0;
    for (int i = 0; i < N_OUT; i++) begin
      if (raddr == ADDR_W'(i)) rb_data = act_i[i*WORD_W +: WORD_W];
    end
  end

  assign rb_oe = rd_req;

  AST_RB_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr >= ADDR_W'(N_OUT)) |-> rb_data == '0); // R7
endmodule

// File: rtl/xbar_switch_matrix.sv
module xbar_switch_matrix #(
  parameter int unsigned N_IN   = 33,
  parameter int unsigned N_OUT  = 17,
  parameter int unsigned SEL_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_OUT*(SEL_W+1)-1:0]  act_i,
  input  logic [N_IN-1:0]             sw_in,
  output wire  [N_OUT-1:0]            sw_out
);
  localparam int unsigned WORD_W = SEL_W + 1;
  localparam int unsigned EXT_W  = 1 << SEL_W;

  logic [EXT_W-1:0] in_ext;
  assign in_ext = {{(EXT_W-N_IN){1'b0}}, sw_in};

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic             en;
    logic [SEL_W-1:0] sel;
    assign sel = act_i[j*WORD_W +: SEL_W];
    assign en  = act_i[j*WORD_W + SEL_W];
    assign sw_out[j] = en ? in_ext[sel] : 1'bz;

    AST_SW_HIGH_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sel >= SEL_W'(N_IN)) |-> sw_out[j] == 1'b0); // R5
  end
endmodule

// File: rtl/xbar_cfg_top.sv
module xbar_cfg_top
  import xbar_cfg_pkg::*;
#(
  parameter int unsigned N_IN   = XB_N_IN,
  parameter int unsigned N_OUT  = XB_N_OUT,
  parameter int unsigned SEL_W  = XB_SEL_W,
  parameter int unsigned ADDR_W = XB_ADDR_W,
  parameter int unsigned SYNC_STAGES = XB_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              dis_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              commit_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  inout  wire  [SEL_W:0]    cfg_data,
  input  logic [N_IN-1:0]   sw_in,
  output wire  [N_OUT-1:0]  sw_out
);
  localparam int unsigned WORD_W = SEL_W + 1;

  logic                    rst_n_s;
  logic                    wr_req, upd_req, rd_req;
  logic [N_OUT*WORD_W-1:0] stage_vec, act_vec;
  logic                    rb_oe;
  logic [WORD_W-1:0]       rb_data;

  assign wr_req  = !cs_n && !wr_n;
  assign upd_req = !cs_n && !commit_n;
  assign rd_req  = !cs_n && !rd_n;

  xbar_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(dis_n), .rst_n_o(rst_n_s)
  );

  xbar_stage_rank #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_n_s), .wr_req(wr_req), .waddr(cfg_addr),
    .wdata(cfg_data), .stage_o(stage_vec)
  );

  xbar_active_rank #(.N_OUT(N_OUT), .WORD_W(WORD_W)) u_active (
    .clk(clk), .rst_n(rst_n_s), .upd_req(upd_req),
    .stage_i(stage_vec), .act_o(act_vec)
  );

  xbar_readback #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rb (
    .clk(clk), .rst_n(rst_n_s), .rd_req(rd_req), .raddr(cfg_addr),
    .act_i(act_vec), .rb_oe(rb_oe), .rb_data(rb_data)
  );

  xbar_switch_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_sw (
    .clk(clk), .rst_n(rst_n_s), .act_i(act_vec), .sw_in(sw_in), .sw_out(sw_out)
  );

  assign cfg_data = rb_oe ? rb_data : {WORD_W{1'bz}};

  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n |=> $stable(act_vec) && $stable(stage_vec)); // R8
  AST_RB_DRIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_req && cfg_addr < ADDR_W'(N_OUT)) |-> cfg_data == rb_data); // R6
endmodule

// File: tb/xbar_cfg_top_tb_top.sv
module xbar_cfg_top_tb_top;
  logic        clk = 1'b0;
  logic        dis_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, commit_n = 1'b1, rd_n = 1'b1;
  logic [4:0]  cfg_addr = '0;
  logic [6:0]  d_drv = '0;
  logic        d_oe = 1'b0;
  logic [32:0] sw_in = '0;
  wire  [6:0]  cfg_data;
  wire  [16:0] sw_out;
  int errs = 0, checks = 0;

  assign cfg_data = d_oe ? d_drv : 7'bz;
  always #10 clk = ~clk;

  xbar_cfg_top dut_i (
    .clk(clk), .dis_n(dis_n), .cs_n(cs_n), .wr_n(wr_n), .commit_n(commit_n),
    .rd_n(rd_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sw_in(sw_in), .sw_out(sw_out)
  );

  // {addr, write word, expected readback}
  localparam logic [18:0] VEC [12] = '{
    {5'd0,  7'h40, 7'h40}, {5'd1,  7'h45, 7'h45}, {5'd2,  7'h60, 7'h60},
    {5'd3,  7'h61, 7'h61}, {5'd4,  7'h0A, 7'h0A}, {5'd5,  7'h7F, 7'h7F},
    {5'd16, 7'h51, 7'h51}, {5'd17, 7'h4C, 7'h00}, {5'd31, 7'h7F, 7'h00},
    {5'd8,  7'h4F, 7'h4F}, {5'd9,  7'h20, 7'h20}, {5'd10, 7'h5F, 7'h5F}
  };
  localparam logic [32:0] PAT0 = 33'h0_A5C3_9E17;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_off(string req, int k);
    checks++;
    if (sw_out[k] === 1'b1) begin
      errs++;
      $display("FAIL %s output %0d actual=1 expected=Z", req, k);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [6:0] d, logic sel = 1'b0, logic commit = 1'b0);
    @(negedge clk);
    cs_n = sel; wr_n = 1'b0; commit_n = ~commit; cfg_addr = a; d_drv = d; d_oe = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; commit_n = 1'b1; d_oe = 1'b0;
  endtask

  task automatic commit(logic sel = 1'b0);
    @(negedge clk);
    cs_n = sel; commit_n = 1'b0; cfg_addr = 5'd27;
    @(negedge clk);
    cs_n = 1'b1; commit_n = 1'b1;
  endtask

  task automatic rd(logic [4:0] a, output logic [6:0] v, input logic sel = 1'b0);
    @(negedge clk);
    cs_n = sel; rd_n = 1'b0; cfg_addr = a;
    #2 v = cfg_data;
    #1 cs_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic route_exp(logic [6:0] w, logic [32:0] pat);
    if (w[5:0] >= 6'd33) return 1'b0;
    return pat[w[5:0]];
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [6:0] v;
    logic [32:0] pat;
    #1 dis_n = 1'b0;
    repeat (3) @(negedge clk);
    dis_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state: all outputs disabled (R9)
    sw_in = '1; #1;
    for (int k = 0; k < 17; k++) check_off("R9 reset state", k);
    rd(5'd0, v);
    check("R9 reset enable bit", 32'(v[6]), 32'd0);

    for (int k = 0; k < 17; k++) wr(5'(k), 7'h00);
    commit();

    // Table walk
    for (int n = 0; n < 12; n++) wr(VEC[n][18:14], VEC[n][13:7]);
    sw_in = '1; #1;
    check_off("R3 no change before commit", 0);
    rd(5'd1, v);
    check("R3 readback before commit", 32'(v), 32'h00);
    commit();
    for (int n = 0; n < 12; n++) begin
      rd(VEC[n][18:14], v);
      check("R1/R6/R7 readback", 32'(v), 32'(VEC[n][6:0]));
    end
    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? PAT0 : ~PAT0;
      @(negedge clk); sw_in = pat; #1;
      for (int n = 0; n < 12; n++) begin
        if (VEC[n][18:14] < 5'd17) begin
          if (!VEC[n][13]) check_off("R4 disabled", int'(VEC[n][18:14]));
          else check("R4/R5 routing", 32'(sw_out[VEC[n][18:14]]), 32'(route_exp(VEC[n][13:7], pat)));
        end
      end
    end

    // R2: several staged words appear together
    wr(5'd6, 7'h41); wr(5'd7, 7'h42);
    rd(5'd6, v); check("R3 staged not active", 32'(v), 32'h00);
    commit();
    rd(5'd6, v); check("R2 commit row 6", 32'(v), 32'h41);
    rd(5'd7, v); check("R2 commit row 7", 32'(v), 32'h42);

    // R8: chip select high blocks everything
    wr(5'd0, 7'h55, 1'b1);
    commit(1'b1);
    rd(5'd0, v, 1'b1); check("R8 bus not driven", 32'(v === 7'h40), 32'd0);
    rd(5'd0, v); check("R8 active unchanged", 32'(v), 32'h40);
    commit();
    rd(5'd0, v); check("R8 staging unchanged", 32'(v), 32'h40);

    // R9: disable while cs high, mid-cycle
    sw_in = '1;
    @(negedge clk); #3 dis_n = 1'b0; #2;
    check_off("R9 immediate disable", 0);
    check_off("R9 immediate disable", 1);
    rd(5'd1, v); check("R9 select kept", 32'(v), 32'h05);
    commit();
    rd(5'd1, v); check("R9 commit held in disable", 32'(v[6]), 32'd0);
    @(negedge clk); dis_n = 1'b1;
    repeat (3) @(negedge clk);
    commit();
    rd(5'd1, v); check("R9 staging restored", 32'(v), 32'h45);

    // R10: write and commit in the same edge
    wr(5'd2, 7'h43, 1'b0, 1'b1);
    rd(5'd2, v); check("R10 commit takes old staging", 32'(v), 32'h60);
    commit();
    rd(5'd2, v); check("R10 new word next commit", 32'(v), 32'h43);
    @(negedge clk); sw_in = PAT0; #1;
    check("R10 routing follows", 32'(sw_out[2]), 32'(PAT0[3]));

    finish_run();
  end
endmodule